// File: doc/BRIEF.md
# Interlocked Shared-Bus Driver Control

This block arbitrates several sources that take turns driving one shared bus. It hands out an output enable to exactly one source at a time. It also produces the value the bus carries, plus a flag that says whether any source is driving.

Each source raises a select when it wants the bus. The sources may request together, so the block picks one. Once a source owns the bus, it keeps it until its own select falls. When ownership passes from one source to another, the block first withdraws every enable for at least one clock. During that turnaround cycle, and whenever nobody drives, the bus output reads as all ones, as if a pull-up held it. The bus never takes an undefined value.

All outputs are registered. A select seen at one clock edge is answered at the next.

Top module: `bus_turn_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: `en_o` all zero, `bus_o` all ones and `driven_o` low. This holds even if selects are active.
- R2: When no enable is on and one or more selects are high at an edge, the lowest-numbered requesting source gets its enable bit (bit i of `en_o` for source i) after that edge.
- R3: While the owning source keeps its select high, it keeps its enable. This is true even when lower-numbered sources also request.
- R4: When the owner's select is low at an edge, all enables are off after that edge, and `bus_o` shows all ones.
- R5: An enable never passes directly from one source to another. Between two different owners there is at least one cycle with `en_o` all zero.
- R6: At most one bit of `en_o` is ever high.
- R7: An enable bit is only high if that source's select was high at the edge that produced it.
- R8: While a source is enabled, `bus_o` equals that source's data word as sampled at the same edge. Source i's word occupies bits [i*DATA_W +: DATA_W] of `data_i`.
- R9: `driven_o` is high exactly when some bit of `en_o` is high. Whenever `driven_o` is low, `bus_o` is all ones.
- R10: With all selects low and no owner, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | NUM_SRC | Per-source bus request |
| data_i | input | NUM_SRC*DATA_W | Per-source data words, source i at [i*DATA_W +: DATA_W] |
| en_o | output | NUM_SRC | Registered one-hot driver enables |
| bus_o | output | DATA_W | Registered bus value, all ones when undriven |
| driven_o | output | 1 | High when a source drives the bus |

## Verification
The hardest situation to reach is a handover under contention. Here the owner drops its select while other sources, including lower-numbered ones, are already requesting. A design that decodes selects straight into enables would switch owners in a single step.

The stimulus holds a wide request pattern, for example all four selects, then lowers only the owner's bit. It then checks that one all-zero enable cycle with a pulled-up bus comes before the next grant.

Data words change while ownership is held. This shows that the bus follows the owner's data and not a value latched at grant time. A data word of all zeros separates a driven bus from the idle level.

// File: rtl/btc_pkg.sv
package btc_pkg;
  // Decision taken by the enable register at each clock edge
  typedef enum logic [1:0] {
    PH_GRANT   = 2'd0,  // no owner: admit the highest-priority request
    PH_KEEP    = 2'd1,  // owner still requesting: hold
    PH_RELEASE = 2'd2   // owner dropped: turnaround cycle with no driver
  } owner_phase_e;
endpackage

// File: rtl/btc_pick.sv
module btc_pick #(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] pick
);
  // blocked[i] is high when any lower-numbered source requests
  logic [NUM_SRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | req[i];
    assign pick[i]      = req[i] & ~blocked[i];
  end
endmodule

// File: rtl/btc_owner.sv
module btc_owner #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] sel,
  input  logic [NUM_SRC-1:0] pick,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_nxt
);
  import btc_pkg::*;

  owner_phase_e phase;
  logic         owned;
  logic         holding;

  assign owned   = |en_q;
  assign holding = |(en_q & sel);

  always_comb begin
    if (!owned)       phase = PH_GRANT;
    else if (holding) phase = PH_KEEP;
    else              phase = PH_RELEASE;
  end

  always_comb begin
    unique case (phase)
      PH_GRANT: en_nxt = pick;
      PH_KEEP:  en_nxt = en_q;
      default:  en_nxt = '0;
    endcase
    if (rst) en_nxt = '0;
  end

  always_ff @(posedge clk) begin
    en_q <= en_nxt;
  end
endmodule

// File: rtl/btc_mux.sv
module btc_mux #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC*DATA_W-1:0] data,
  output logic [DATA_W-1:0]         bus
);
  // AND-OR selection; the one-hot enable guarantees a single term survives
  logic [DATA_W-1:0] acc [NUM_SRC+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_term
    assign acc[i+1] = acc[i] | (data[i*DATA_W +: DATA_W] & {DATA_W{en[i]}});
  end

  // Pull-up: undriven bus reads as all ones
  assign bus = (|en) ? acc[NUM_SRC] : {DATA_W{1'b1}};
endmodule

// File: rtl/bus_turn_ctrl.sv
module bus_turn_ctrl #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        sel_i,
  input  logic [NUM_SRC*DATA_W-1:0] data_i,
  output logic [NUM_SRC-1:0]        en_o,
  output logic [DATA_W-1:0]         bus_o,
  output logic                      driven_o
);
  localparam logic [DATA_W-1:0] IDLE_LEVEL = {DATA_W{1'b1}};

  logic [NUM_SRC-1:0] pick;
  logic [NUM_SRC-1:0] en_nxt;
  logic [DATA_W-1:0]  bus_nxt;

  btc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req  (sel_i),
    .pick (pick)
  );

  btc_owner #(.NUM_SRC(NUM_SRC)) u_owner (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel_i),
    .pick   (pick),
    .en_q   (en_o),
    .en_nxt (en_nxt)
  );

  btc_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mux (
    .en   (en_nxt),
    .data (data_i),
    .bus  (bus_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_o    <= IDLE_LEVEL;
      driven_o <= 1'b0;
    end else begin
      bus_o    <= bus_nxt;
      driven_o <= |en_nxt;
    end
  end
endmodule

// File: rtl/bus_turn_ctrl_chk.sv
module bus_turn_ctrl_chk #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] sel_i,
  input logic [NUM_SRC-1:0] en_o,
  input logic [DATA_W-1:0]  bus_o,
  input logic               driven_o
);
  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_o));

  // R5
  no_direct_handover_chk: assert property (@(posedge clk) disable iff (rst)
    (|en_o) |=> ((en_o == '0) || (en_o == $past(en_o))));

  // R7
  grant_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    (|en_o) |-> ((en_o & $past(sel_i)) != '0));

  // R3
  owner_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    ((|en_o) && ((en_o & sel_i) != '0)) |=> $stable(en_o));

  // R4
  owner_release_chk: assert property (@(posedge clk) disable iff (rst)
    ((|en_o) && ((en_o & sel_i) == '0)) |=> (en_o == '0));

  // R9
  driven_flag_chk: assert property (@(posedge clk) disable iff (rst)
    driven_o == (en_o != '0));

  // R9
  pullup_level_chk: assert property (@(posedge clk) disable iff (rst)
    !driven_o |-> (bus_o == {DATA_W{1'b1}}));
endmodule

bind bus_turn_ctrl bus_turn_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_i    (sel_i),
  .en_o     (en_o),
  .bus_o    (bus_o),
  .driven_o (driven_o)
);

// File: tb/bus_turn_ctrl_bench.sv
`timescale 1ns/1ps
module bus_turn_ctrl_bench;
  localparam int N = 4;
  localparam int W = 8;
  localparam int NV = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   sel_i;
  logic [N*W-1:0] data_i;
  logic [N-1:0]   en_o;
  logic [W-1:0]   bus_o;
  logic           driven_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_turn_ctrl #(.NUM_SRC(N), .DATA_W(W)) u_bus_turn_ctrl (
    .clk(clk), .rst(rst), .sel_i(sel_i), .data_i(data_i),
    .en_o(en_o), .bus_o(bus_o), .driven_o(driven_o)
  );

  // {sel[4], data[32], expected en[4], expected bus[8], expected driven[1]}
  localparam logic [48:0] VEC [NV] = '{
    {4'b0000, 32'hD3C2B1A0, 4'b0000, 8'hFF, 1'b0},  // R10 idle stays idle
    {4'b0110, 32'hD3C2B1A0, 4'b0010, 8'hB1, 1'b1},  // R2 lowest of 1,2
    {4'b0111, 32'h44332211, 4'b0010, 8'h22, 1'b1},  // R3 hold vs src0
    {4'b0101, 32'h44332211, 4'b0000, 8'hFF, 1'b0},  // R4 release
    {4'b0101, 32'h44332211, 4'b0001, 8'h11, 1'b1},  // R5 grant after gap
    {4'b1000, 32'h44332211, 4'b0000, 8'hFF, 1'b0},  // R5 no direct handover
    {4'b1000, 32'h9F000000, 4'b1000, 8'h9F, 1'b1},  // R8 src3 data
    {4'b1000, 32'h00000000, 4'b1000, 8'h00, 1'b1},  // R8 zero word driven
    {4'b0000, 32'h00000000, 4'b0000, 8'hFF, 1'b0},  // R9 undriven level
    {4'b1111, 32'hD3C2B1A0, 4'b0001, 8'hA0, 1'b1},  // R2 all request
    {4'b1110, 32'hD3C2B1A0, 4'b0000, 8'hFF, 1'b0},  // R4 release under load
    {4'b1110, 32'hD3C2B1A0, 4'b0010, 8'hB1, 1'b1}   // R7 only requesters
  };

  function automatic string vreq(int i);
    case (i)
      0: return "R10";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";   5: return "R5";  6: return "R8";  7: return "R8";
      8: return "R9";   9: return "R2";  10: return "R4"; default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [N-1:0] ee, logic [W-1:0] eb, logic ed);
    checks++;
    if (en_o !== ee || bus_o !== eb || driven_o !== ed) begin
      fails++;
      $display("FAIL %s: en=%b bus=%h drv=%b, expected en=%b bus=%h drv=%b",
               req, en_o, bus_o, driven_o, ee, eb, ed);
    end
  endtask

  task automatic step(logic [N-1:0] s, logic [N*W-1:0] d);
    sel_i  = s;
    data_i = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst    = 1'b1;
    sel_i  = '0;
    data_i = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1", 4'b0000, 8'hFF, 1'b0);  // R1 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][48:45], VEC[i][44:13]);
      check(vreq(i), VEC[i][12:9], VEC[i][8:1], VEC[i][0]);
    end

    // R1: reset while owned and selects active
    rst = 1'b1;
    step(4'b1110, 32'hD3C2B1A0);
    check("R1", 4'b0000, 8'hFF, 1'b0);
    rst = 1'b0;

    // R2: first grant after reset goes to src2
    step(4'b0100, 32'hD3C2B1A0);
    check("R2", 4'b0100, 8'hC2, 1'b1);

    // R3/R8: src2 keeps the bus under full contention while its data changes
    for (int k = 0; k < 5; k++) begin
      logic [7:0] v;
      v = 8'h30 + 8'(k);
      step(4'b1111, {8'h00, v, 8'h00, 8'h00});
      check("R3", 4'b0100, v, 1'b1);
    end

    // R4 then R2: owner drops with everyone else requesting
    step(4'b1011, 32'hD3C2B1A0);
    check("R4", 4'b0000, 8'hFF, 1'b0);
    step(4'b1011, 32'hD3C2B1A0);
    check("R2", 4'b0001, 8'hA0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule